// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block chooses which of several interrupt sources a CPU services. It runs beside the instruction sequencer and reaches its decision only at instruction boundaries. Each source is built as one of two kinds, selected per source by a parameter. An edge or event source sets a pending latch that holds until the source is serviced or software clears it. A level source has no latch and counts only while its input condition is present.

A request is taken only when its own enable and the global enable are both set, and the lowest-numbered source wins. On a take the block does several things at once. It pulses a take strobe and presents a vector address. It clears the global enable and issues a one-cycle automatic clear to the winning latch. It also stays busy for the interrupt response window, which is longer when the CPU was asleep.

The sequencer reports four things to the block: instruction retirement, enable-interrupts, disable-interrupts and return-from-interrupt. Enable and return each impose a one-instruction grace period. Disable takes effect in the very cycle it is reported.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Among requesting sources the lowest index wins. The vector is base + 2*(index+1), and vector base + 0 is left to reset.
- R2: A take happens only when the global enable and the source's own enable are both 1.
- R3: The global enable is 0 after reset. It becomes 1 at the edge after `sei_i` or `reti_i`, and it is 0 in the cycle `take_o` is high.
- R4: Taking an event source clears its pending bit at the same edge, with a one-hot `ack_clr_o` pulse alongside `take_o`. A 1 in `flag_w1c_i[i]` clears `pend_o[i]` unless a new event arrives in that same cycle, in which case the event wins.
- R5: An event that arrives while the source or the global enable is off stays in `pend_o` and is served once both enables are on.
- R6: A level source never shows in `pend_o`. If its condition ends before it is enabled, no take follows, and its take gives no `ack_clr_o`.
- R7: No take occurs in the retire cycle that carries `sei_i` or `reti_i`. A take is allowed at the next retire.
- R8: `cli_i` blocks a take in its own cycle, even if a request is present.
- R9: After a take, `busy_o` stays high for RESP_CYC cycles, or RESP_CYC+WAKE_CYC cycles if `sleep_i` was high at the take. No take occurs while busy.
- R10: A take happens only in a cycle with `retire_i` high, and `take_o` follows it one cycle later.
- R11: With `relocate_i` high at the take, the vector uses BOOT_BASE instead of APP_BASE.
- R12: After reset, `pend_o`, `gie_o`, `take_o`, `ack_clr_o`, `busy_o` and `vec_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_evt_i | input | N_SRC | Source conditions (event or level, per LEVEL_MASK) |
| src_en_i | input | N_SRC | Per-source enables |
| flag_w1c_i | input | N_SRC | Software clear of pending bits, one bit per source |
| retire_i | input | 1 | An instruction completes in this cycle |
| sei_i | input | 1 | The retiring instruction enables interrupts |
| cli_i | input | 1 | The retiring instruction disables interrupts |
| reti_i | input | 1 | The retiring instruction returns from an interrupt |
| sleep_i | input | 1 | The CPU is asleep, which lengthens the response |
| relocate_i | input | 1 | Use the boot-section vector base |
| take_o | output | 1 | One-cycle take strobe |
| vec_o | output | VEC_W | Vector address of the last take |
| src_id_o | output | IDX_W | Index of the last taken source |
| ack_clr_o | output | N_SRC | One-hot automatic pending clear |
| pend_o | output | N_SRC | Pending latches |
| gie_o | output | 1 | Global enable |
| busy_o | output | 1 | Response window in progress |

## Verification
The bench builds the block with eight sources and marks the top two as level sources, so both kinds of source and the priority between them show up in one run. The boot base is set to 0xF000, which makes any relocation visible in the vector. A response time of five cycles plus a five-cycle wake penalty keeps both busy windows short, so random traffic often collides with them and with the grace periods.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

   // Indications from the CPU sequencer, packed together for internal use
   typedef struct packed {
      logic retire;
      logic sei;
      logic cli;
      logic reti;
      logic sleep;
   } core_ind_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ivc_src_bank.sv
module ivc_src_bank #(
   parameter int unsigned          N_SRC      = 8,
   parameter logic [N_SRC-1:0]     LEVEL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt,
   input  logic [N_SRC-1:0] w1c,
   input  logic [N_SRC-1:0] ack,
   output logic [N_SRC-1:0] pend,
   output logic [N_SRC-1:0] raw_req
);

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (LEVEL_MASK[i]) begin : g_level
         assign pend[i]    = 1'b0;
         assign raw_req[i] = evt[i];
      end else begin : g_flag
         logic latch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               latch_q <= 1'b0;
            else
               latch_q <= (latch_q & ~w1c[i] & ~ack[i]) | evt[i];
         end
         assign pend[i]    = latch_q;
         assign raw_req[i] = latch_q;

         // R5: an event is always remembered
         p_evt_latched_r5 : assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> latch_q);
         // R4: software clear without a new event empties the latch
         p_w1c_clears_r4 : assert property (@(posedge clk) disable iff (!rst_n)
            (w1c[i] && !evt[i]) |=> !latch_q);
      end
   end

endmodule

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick #(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N_SRC-1:0] req,
   output logic             hit,
   output logic [IDX_W-1:0] idx,
   output logic [N_SRC-1:0] onehot
);

   always_comb begin
      hit    = 1'b0;
      idx    = '0;
      onehot = '0;
      // scan from the top so the lowest requesting index is kept last
      for (int k = N_SRC - 1; k >= 0; k--) begin
         if (req[k]) begin
            hit    = 1'b1;
            idx    = IDX_W'(k);
            onehot = '0;
            onehot[k] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ivc_seq.sv
module ivc_seq
   import ivc_pkg::*;
#(
   parameter int unsigned RESP_CYC = 5,
   parameter int unsigned WAKE_CYC = 5,
   localparam int unsigned CNT_W   = $clog2(RESP_CYC + WAKE_CYC + 1)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  core_ind_t ind,
   input  logic      any_req,
   output logic      take_d,
   output logic      gie_q,
   output logic      busy
);

   localparam logic [CNT_W-1:0] LOAD_AWAKE = CNT_W'(RESP_CYC);
   localparam logic [CNT_W-1:0] LOAD_SLEEP = CNT_W'(RESP_CYC + WAKE_CYC);

   logic [CNT_W-1:0] cnt_q;
   logic             grace;

   assign busy   = (cnt_q != '0);
   assign grace  = ind.sei | ind.reti;
   assign take_d = ind.retire & gie_q & ~ind.cli & ~grace & ~busy & any_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (take_d || ind.cli)
            gie_q <= 1'b0;
         else if (grace)
            gie_q <= 1'b1;

         if (take_d)
            cnt_q <= ind.sleep ? LOAD_SLEEP : LOAD_AWAKE;
         else if (busy)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   // R3: enable or return sets the global enable
   p_gie_set_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (grace && !ind.cli) |=> gie_q);
   // R8: disable clears the global enable
   p_gie_cli_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      ind.cli |=> !gie_q);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import ivc_pkg::*;
#(
   parameter int unsigned      N_SRC      = 8,
   parameter logic [N_SRC-1:0] LEVEL_MASK = '0,
   parameter int unsigned      VEC_W      = 16,
   parameter logic [VEC_W-1:0] APP_BASE   = '0,
   parameter logic [VEC_W-1:0] BOOT_BASE  = '0,
   parameter int unsigned      RESP_CYC   = 5,
   parameter int unsigned      WAKE_CYC   = 5,
   localparam int unsigned     IDX_W      = idx_width(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_evt_i,
   input  logic [N_SRC-1:0] src_en_i,
   input  logic [N_SRC-1:0] flag_w1c_i,
   input  logic             retire_i,
   input  logic             sei_i,
   input  logic             cli_i,
   input  logic             reti_i,
   input  logic             sleep_i,
   input  logic             relocate_i,
   output logic             take_o,
   output logic [VEC_W-1:0] vec_o,
   output logic [IDX_W-1:0] src_id_o,
   output logic [N_SRC-1:0] ack_clr_o,
   output logic [N_SRC-1:0] pend_o,
   output logic             gie_o,
   output logic             busy_o
);

   if (N_SRC < 2) begin : g_bad_nsrc
      $error("N_SRC must be at least 2");
   end
   if (VEC_W < IDX_W + 3) begin : g_bad_vecw
      $error("VEC_W too narrow for the vector table");
   end
   if (RESP_CYC < 1) begin : g_bad_resp
      $error("RESP_CYC must be at least 1");
   end

   core_ind_t        ind;
   logic [N_SRC-1:0] raw_req, req, win_hot, ack_now;
   logic             hit, take_d;
   logic [IDX_W-1:0] win_idx;
   logic [VEC_W-1:0] base_sel, vec_next;

   assign ind = '{retire: retire_i, sei: sei_i, cli: cli_i, reti: reti_i, sleep: sleep_i};

   ivc_src_bank #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (src_evt_i),
      .w1c     (flag_w1c_i),
      .ack     (ack_now),
      .pend    (pend_o),
      .raw_req (raw_req)
   );

   assign req = raw_req & src_en_i;

   ivc_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
      .req    (req),
      .hit    (hit),
      .idx    (win_idx),
      .onehot (win_hot)
   );

   ivc_seq #(.RESP_CYC(RESP_CYC), .WAKE_CYC(WAKE_CYC)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .ind     (ind),
      .any_req (hit),
      .take_d  (take_d),
      .gie_q   (gie_o),
      .busy    (busy_o)
   );

   assign ack_now  = take_d ? (win_hot & ~LEVEL_MASK) : '0;
   assign base_sel = relocate_i ? BOOT_BASE : APP_BASE;
   assign vec_next = base_sel
                   + {{(VEC_W-IDX_W-2){1'b0}}, ({1'b0, win_idx} + 1'b1), 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o    <= 1'b0;
         vec_o     <= '0;
         src_id_o  <= '0;
         ack_clr_o <= '0;
      end else begin
         take_o    <= take_d;
         ack_clr_o <= ack_now;
         if (take_d) begin
            vec_o    <= vec_next;
            src_id_o <= win_idx;
         end
      end
   end

   // R2: a take needs the global enable
   p_take_gie_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(gie_o));
   // R10: takes only at instruction boundaries
   p_take_boundary_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(retire_i));
   // R3: acceptance drops the global enable
   p_gie_drop_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> !gie_o);
   // R8: disable blocks in the same cycle
   p_cli_block_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(cli_i) |-> !take_o);
   // R7: grace instruction after enable or return
   p_grace_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(sei_i || reti_i) |-> !take_o);
   // R9: a take opens a fresh response window
   p_busy_window_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (busy_o && !$past(busy_o)));
   // R4: automatic clear is one-hot and only with a take
   p_ack_onehot_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_clr_o) && ((ack_clr_o != '0) -> take_o));
   // R1: vectors stay word-pair aligned
   p_vec_even_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (vec_o[0] == 1'b0));

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;

   localparam int          N     = 8;
   localparam logic [7:0]  LVL   = 8'hC0;
   localparam logic [15:0] APPB  = 16'h0000;
   localparam logic [15:0] BOOTB = 16'hF000;
   localparam int          RESP  = 5;
   localparam int          WAKE  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] evt = '0, en = '0, w1c = '0;
   logic retire = 0, sei = 0, cli = 0, reti = 0, sleep = 0, reloc = 0;

   logic        take_o, gie_o, busy_o;
   logic [15:0] vec_o;
   logic [2:0]  src_id_o;
   logic [N-1:0] ack_clr_o, pend_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // reference model state
   logic [N-1:0] m_pend;
   logic         m_gie, m_take;
   logic [15:0]  m_vec;
   logic [N-1:0] m_ack;
   int           m_cnt;

   always #10 clk = ~clk;

   irq_vector_ctrl #(
      .N_SRC(N), .LEVEL_MASK(LVL), .VEC_W(16), .APP_BASE(APPB),
      .BOOT_BASE(BOOTB), .RESP_CYC(RESP), .WAKE_CYC(WAKE)
   ) dut (
      .clk(clk), .rst_n(rst_n), .src_evt_i(evt), .src_en_i(en),
      .flag_w1c_i(w1c), .retire_i(retire), .sei_i(sei), .cli_i(cli),
      .reti_i(reti), .sleep_i(sleep), .relocate_i(reloc),
      .take_o(take_o), .vec_o(vec_o), .src_id_o(src_id_o),
      .ack_clr_o(ack_clr_o), .pend_o(pend_o), .gie_o(gie_o), .busy_o(busy_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_vec(input int idx, input logic rel);
      return (rel ? BOOTB : APPB) + 16'((idx + 1) * 2);
   endfunction

   // one clock: predict, advance, compare at the falling edge
   task automatic step();
      logic [N-1:0] req, clr, n_pend;
      bit ok;
      int idx;
      req = (m_pend | (evt & LVL)) & en;
      ok  = retire && m_gie && !cli && !sei && !reti && (m_cnt == 0) && (req != 0);
      idx = 0;
      for (int k = N - 1; k >= 0; k--) if (req[k]) idx = k;
      clr = (ok && !LVL[idx]) ? (N'(1) << idx) : '0;
      n_pend = (m_pend & ~w1c & ~clr) | (evt & ~LVL);
      @(posedge clk);
      @(negedge clk);
      cycles++;
      m_pend = n_pend;
      m_take = ok;
      m_ack  = clr;
      if (ok) m_vec = exp_vec(idx, reloc);
      if (ok) m_cnt = sleep ? RESP + WAKE : RESP;
      else if (m_cnt > 0) m_cnt--;
      if (ok || cli) m_gie = 0;
      else if (sei || reti) m_gie = 1;
      chk(take_o === m_take, "R2 take", 32'(take_o), 32'(m_take));
      chk(vec_o === m_vec, "R1 vector", 32'(vec_o), 32'(m_vec));
      chk(pend_o === m_pend, "R4 pending", 32'(pend_o), 32'(m_pend));
      chk(ack_clr_o === m_ack, "R4 autoclear", 32'(ack_clr_o), 32'(m_ack));
      chk(gie_o === m_gie, "R3 global enable", 32'(gie_o), 32'(m_gie));
      chk(busy_o === (m_cnt != 0), "R9 busy", 32'(busy_o), 32'(m_cnt != 0));
   endtask

   task automatic ins(input bit r, input bit s, input bit c, input bit ri);
      retire = r; sei = s; cli = c; reti = ri;
      step();
      retire = 0; sei = 0; cli = 0; reti = 0;
   endtask

   task automatic drain();
      while (busy_o) ins(0, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int n;
      void'($urandom(32'd20240611));
      m_pend = '0; m_gie = 0; m_take = 0; m_vec = '0; m_ack = '0; m_cnt = 0;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(pend_o == 0 && gie_o == 0 && take_o == 0, "R12 reset flags",
          {pend_o, 22'(0), gie_o, take_o}, 0);
      chk(busy_o == 0 && ack_clr_o == 0 && vec_o == 0, "R12 reset outputs",
          {busy_o, ack_clr_o, vec_o}, 0);
      rst_n = 1;

      ins(1, 1, 0, 0);            // enable interrupts
      ins(1, 0, 0, 0);
      chk(gie_o == 1, "R3 set by sei", 32'(gie_o), 1);

      // R6: level condition gone before enable leaves nothing behind
      en = '0; evt = 8'h40; ins(1, 0, 0, 0);
      evt = '0; en = 8'h40;
      n = 0;
      repeat (3) begin ins(1, 0, 0, 0); n += int'(take_o); end
      chk(n == 0, "R6 no late level take", 32'(n), 0);
      chk(pend_o[6] == 0, "R6 no level latch", 32'(pend_o[6]), 0);

      // R5: latched while disabled, served when enabled
      en = '0; evt = 8'h04; ins(1, 0, 0, 0);
      evt = '0; ins(1, 0, 0, 0);
      chk(pend_o[2] == 1 && take_o == 0, "R5 held while disabled", 32'(pend_o), 8'h04);
      en = 8'h3F; ins(1, 0, 0, 0);
      chk(take_o == 1 && vec_o == 16'h0006, "R5 served vector", 32'(vec_o), 16'h0006);
      chk(ack_clr_o == 8'h04 && pend_o[2] == 0, "R4 autoclear on take",
          32'(ack_clr_o), 8'h04);
      chk(gie_o == 0, "R3 cleared on take", 32'(gie_o), 0);
      n = 0;
      while (busy_o) begin n++; ins(1, 0, 0, 0); end
      chk(n == RESP, "R9 response length", 32'(n), RESP);

      // R7: grace instruction after sei
      evt = 8'h02; ins(0, 0, 0, 0); evt = '0;
      ins(1, 1, 0, 0);
      chk(take_o == 0, "R7 none on sei retire", 32'(take_o), 0);
      ins(1, 0, 0, 0);
      chk(take_o == 1 && vec_o == 16'h0004, "R7 take after grace", 32'(vec_o), 16'h0004);
      drain();

      // R7 again after reti
      evt = 8'h01; ins(0, 0, 0, 0); evt = '0;
      ins(1, 0, 0, 1);
      chk(take_o == 0, "R7 none on reti retire", 32'(take_o), 0);
      ins(1, 0, 0, 0);
      chk(take_o == 1 && src_id_o == 0, "R7 take after reti", 32'(src_id_o), 0);
      drain();

      // R8: cli in the same cycle as a request
      evt = 8'h08; ins(0, 0, 0, 0); evt = '0;
      ins(1, 1, 0, 0);
      ins(1, 0, 1, 0);
      chk(take_o == 0 && gie_o == 0, "R8 cli blocks", 32'(take_o), 0);
      chk(pend_o[3] == 1, "R8 request kept", 32'(pend_o[3]), 1);

      // R10 and R11
      ins(1, 1, 0, 0);
      ins(0, 0, 0, 0);
      chk(take_o == 0, "R10 no take without retire", 32'(take_o), 0);
      reloc = 1; ins(1, 0, 0, 0); reloc = 0;
      chk(take_o == 1 && vec_o == 16'hF008, "R11 boot base", 32'(vec_o), 16'hF008);
      drain();

      // R1 priority, R6 level ack, R9 wake penalty
      evt = 8'hB0; en = 8'hFF; ins(0, 0, 0, 0);
      evt = 8'h80;
      ins(1, 1, 0, 0);
      ins(1, 0, 0, 0);
      chk(take_o == 1 && vec_o == 16'h000A, "R1 lowest index wins", 32'(vec_o), 16'h000A);
      drain();
      w1c = 8'h20; ins(0, 0, 0, 0); w1c = '0;
      chk(pend_o[5] == 0, "R4 software clear", 32'(pend_o), 0);
      ins(1, 1, 0, 0);
      sleep = 1; ins(1, 0, 0, 0); sleep = 0;
      chk(take_o == 1 && vec_o == 16'h0010 && ack_clr_o == 0, "R6 level take no ack",
          32'(vec_o), 16'h0010);
      evt = '0;
      n = 0;
      while (busy_o) begin n++; ins(1, 0, 0, 0); end
      chk(n == RESP + WAKE, "R9 wake response length", 32'(n), RESP + WAKE);

      // constrained random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         int sel;
         evt    = N'($urandom & $urandom & $urandom);
         en     = N'($urandom | $urandom);
         w1c    = N'($urandom & $urandom & $urandom & $urandom);
         sleep  = ($urandom % 8) == 0;
         reloc  = ($urandom % 16) == 0;
         retire = ($urandom % 4) != 0;
         sel    = int'($urandom % 16);
         sei    = retire && (sel == 0 || sel == 3);
         cli    = retire && sel == 1;
         reti   = retire && sel == 2;
         step();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule